// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block sits in the load/store path and decides, for one data access per request, which physical address it goes to and whether it may proceed. It takes the virtual address, the access size, a store flag, a physical-bypass flag, a page-table-fetch flag, the program-counter low bit, an alternate-mode flag, the current and alternate privilege modes and a superpage enable. It answers one cycle later with a physical address, an uncacheable flag, a fault code and a six-bit status vector.

Translation storage lives outside. The block drives the virtual page number on `lk_vpn` and the external lookup structure answers in the same cycle with a hit, a physical page number, per-mode read and write enable masks and two fault-on bits. The checks are applied in a fixed priority: misalignment, then address validity, then the superpage window, then lookup miss, then per-mode permission, then the fault-on bits, then the implemented physical range, and last the uncached and register space decoding. The first check that fails decides the fault code and the status bits.

Top module: `dxl_check`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_fault` is 0, `rsp_flags` is 0 and `rsp_pa` is 0.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low after a cycle with `req_valid` low. Results are registered with the same one-cycle delay.
- R3: The access size is 2^`req_size_log2` bytes. If `req_va` AND (size-1) is nonzero, the fault is ALIGN (1) ahead of every other check, and the status is only the store bit (bit 0) when `req_write` is 1.
- R4: With `req_phys` set, the raw physical address is `req_va`. The lookup result and the permissions are ignored. Any set bit at or above bit 44 then gives MCHK (8).
- R5: If bits 63:47 of the virtual address are not all equal, the fault is BADVA (2) with status bits 1 (bad address) and 2 (violation), plus bit 0 on stores.
- R6: With `spage_en` set and VA bits 47:41 equal to 0x7e, the access is a superpage. If `cur_mode` is not kernel (0), the fault is SPAGE (3) with status bit 2, plus bit 0 on stores. Otherwise the raw address is VA bits 43:0, with bits 43:40 forced to one when bit 40 is one, or bits above 39 cleared when bit 40 is zero.
- R7: A lookup miss sets status bit 3 (plus bit 0 on stores). The fault is MISS_PTE (5) when `req_pte` is set and MISS (4) otherwise.
- R8: On a hit the raw address is `lk_ppn` shifted left by 13, OR the low 13 VA bits.
- R9: The effective mode is `cur_mode`, except when `req_pc_low` is 1. In that case it is `alt_mode` if `req_alt` is set and kernel (0) if not. Modes are 0 kernel, 1 executive, 2 supervisor, 3 user.
- R10: If the enable bit of the effective mode is clear (`lk_wr_en` for stores, `lk_rd_en` for loads), the fault is ACCESS (6). Status is bit 2, plus bit 0 and fault-on-write bit 5 (if `lk_fault_wr`) on stores, or fault-on-read bit 4 (if `lk_fault_rd`) on loads.
- R11: If access is permitted but the fault-on bit for the direction is set, the fault is FAULTON (7). Status is bits 0 and 5 on a store, or bit 4 alone on a load.
- R12: If raw address bit 43 is set and bits 42:41 are 01, the fault is UNIMP (9). If bit 43 is set otherwise, `rsp_uncache` is 1 and bits 42:35 of `rsp_pa` are cleared.
- R13: Fault code 0 means no fault. On any fault `rsp_pa` is 0 and `rsp_uncache` is 0. MCHK and UNIMP carry a status of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_va | input | 64 | Virtual address |
| req_size_log2 | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Store access |
| req_phys | input | 1 | Physical bypass |
| req_alt | input | 1 | Use alternate mode when PC low bit set |
| req_pte | input | 1 | Access fetches a page table entry |
| req_pc_low | input | 1 | Program counter bit 0 |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| spage_en | input | 1 | Superpage window enable |
| lk_vpn | output | 35 | Virtual page number to the lookup |
| lk_hit | input | 1 | Lookup hit |
| lk_ppn | input | 31 | Physical page number |
| lk_rd_en | input | 4 | Read enable per mode |
| lk_wr_en | input | 4 | Write enable per mode |
| lk_fault_rd | input | 1 | Fault on read |
| lk_fault_wr | input | 1 | Fault on write |
| rsp_valid | output | 1 | Result present |
| rsp_pa | output | 44 | Physical address |
| rsp_uncache | output | 1 | Uncacheable access |
| rsp_fault | output | 4 | Fault code |
| rsp_flags | output | 6 | Status bits |

## Verification
The bench builds the block with its default parameters: a 64-bit virtual address, 48 implemented virtual bits, 44 physical bits, a 13-bit page and four modes, with superpage sign extension enabled. This geometry places the uncached bit at 43, the sign-extension bit at 40 and the cleared field at 42:35. Every priority step, both superpage extension cases, the register space decode and the physical-range check can therefore be reached with literal addresses. The vector table pairs each access with a lookup answer chosen to make exactly one check decide, and it includes cases where a lower-priority condition is also present.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

   typedef enum logic [3:0] {
      DXL_OK       = 4'd0,
      DXL_ALIGN    = 4'd1,
      DXL_BADVA    = 4'd2,
      DXL_SPAGE    = 4'd3,
      DXL_MISS     = 4'd4,
      DXL_MISS_PTE = 4'd5,
      DXL_ACCESS   = 4'd6,
      DXL_FAULTON  = 4'd7,
      DXL_MCHK     = 4'd8,
      DXL_UNIMP    = 4'd9
   } dxl_fault_e;

   localparam int FL_W     = 6;
   localparam int FL_WR    = 0;
   localparam int FL_BADVA = 1;
   localparam int FL_ACV   = 2;
   localparam int FL_MISS  = 3;
   localparam int FL_FONR  = 4;
   localparam int FL_FONW  = 5;

   localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/dxl_mode_sel.sv
module dxl_mode_sel #(
   parameter int MODE_W = 2
) (
   input  logic              pc_low,
   input  logic              use_alt,
   input  logic [MODE_W-1:0] cur,
   input  logic [MODE_W-1:0] alt,
   output logic [MODE_W-1:0] eff
);
   always_comb begin
      if (!pc_low)      eff = cur;
      else if (use_alt) eff = alt;
      else              eff = '0;
   end
endmodule

// File: rtl/dxl_perm.sv
module dxl_perm
   import dxl_pkg::*;
#(
   parameter int NMODE  = 4,
   parameter int MODE_W = $clog2(NMODE)
) (
   input  logic              is_wr,
   input  logic [MODE_W-1:0] mode,
   input  logic [NMODE-1:0]  rd_en,
   input  logic [NMODE-1:0]  wr_en,
   input  logic              fo_rd,
   input  logic              fo_wr,
   output dxl_fault_e        fault,
   output logic [FL_W-1:0]   flags
);
   logic allowed;
   logic fo_hit;

   always_comb begin
      allowed = is_wr ? wr_en[mode] : rd_en[mode];
      fo_hit  = is_wr ? fo_wr : fo_rd;
      fault   = DXL_OK;
      flags   = '0;
      if (!allowed) begin
         fault          = DXL_ACCESS;
         flags[FL_ACV]  = 1'b1;
         flags[FL_WR]   = is_wr;
         flags[FL_FONW] = is_wr & fo_wr;
         flags[FL_FONR] = ~is_wr & fo_rd;
      end else if (fo_hit) begin
         fault          = DXL_FAULTON;
         flags[FL_WR]   = is_wr;
         flags[FL_FONW] = is_wr;
         flags[FL_FONR] = ~is_wr;
      end
   end
endmodule

// File: rtl/dxl_pa_post.sv
module dxl_pa_post
   import dxl_pkg::*;
#(
   parameter int CHK_W = 64,
   parameter int PA_W  = 44
) (
   input  logic [CHK_W-1:0] raw,
   output dxl_fault_e       fault,
   output logic             unc,
   output logic [PA_W-1:0]  pa
);
   localparam int UNC_BIT = PA_W - 1;
   localparam int CLR_HI  = PA_W - 2;
   localparam int CLR_LO  = PA_W - 9;

   always_comb begin
      fault = DXL_OK;
      unc   = 1'b0;
      pa    = raw[PA_W-1:0];
      if (|raw[CHK_W-1:PA_W]) begin
         fault = DXL_MCHK;
         pa    = '0;
      end else if (raw[UNC_BIT]) begin
         if (raw[CLR_HI -: 2] == 2'b01) begin
            fault = DXL_UNIMP;
            pa    = '0;
         end else begin
            unc                = 1'b1;
            pa[CLR_HI:CLR_LO]  = '0;
         end
      end
   end
endmodule

// File: rtl/dxl_check.sv
module dxl_check
   import dxl_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int VA_IMPL_W   = 48,
   parameter int PA_W        = 44,
   parameter int PAGE_SHIFT  = 13,
   parameter int NMODE       = 4,
   parameter bit SP_SIGN_EXT = 1'b1,
   localparam int MODE_W     = $clog2(NMODE),
   localparam int PPN_W      = PA_W - PAGE_SHIFT,
   localparam int VPN_W      = VA_IMPL_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [1:0]        req_size_log2,
   input  logic              req_write,
   input  logic              req_phys,
   input  logic              req_alt,
   input  logic              req_pte,
   input  logic              req_pc_low,
   input  logic [MODE_W-1:0] cur_mode,
   input  logic [MODE_W-1:0] alt_mode,
   input  logic              spage_en,
   output logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_hit,
   input  logic [PPN_W-1:0]  lk_ppn,
   input  logic [NMODE-1:0]  lk_rd_en,
   input  logic [NMODE-1:0]  lk_wr_en,
   input  logic              lk_fault_rd,
   input  logic              lk_fault_wr,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_uncache,
   output logic [3:0]        rsp_fault,
   output logic [FL_W-1:0]   rsp_flags
);
   localparam int SX_BIT = PA_W - 4;
   localparam int CLR_HI = PA_W - 2;
   localparam int CLR_LO = PA_W - 9;
   localparam logic [VA_W-1:0] PA_MASK = (VA_W'(1) << PA_W) - VA_W'(1);
   localparam logic [6:0] SP_TAG = 7'h7e;

   if (VA_IMPL_W < PAGE_SHIFT + 8 || VA_IMPL_W > VA_W) begin : g_bad_va
      $error("dxl_check: VA_IMPL_W out of range");
   end
   if (PA_W < PAGE_SHIFT + 9 || PA_W >= VA_W) begin : g_bad_pa
      $error("dxl_check: PA_W out of range");
   end
   if (NMODE < 2 || (1 << MODE_W) != NMODE) begin : g_bad_mode
      $error("dxl_check: NMODE must be a power of two");
   end

   assign lk_vpn = req_va[VA_IMPL_W-1:PAGE_SHIFT];

   logic [VA_W-1:0] align_mask;
   logic            misaligned, va_ok, is_sp;
   logic [VA_W-VA_IMPL_W:0] va_top;

   assign align_mask = (VA_W'(1) << req_size_log2) - VA_W'(1);
   assign misaligned = |(req_va & align_mask);
   assign va_top     = req_va[VA_W-1:VA_IMPL_W-1];
   assign va_ok      = (&va_top) | ~(|va_top);
   assign is_sp      = spage_en && (req_va[VA_IMPL_W-1 -: 7] == SP_TAG);

   logic [VA_W-1:0] sp_pa;
   if (SP_SIGN_EXT) begin : g_sx
      always_comb begin
         sp_pa = req_va & PA_MASK;
         if (sp_pa[SX_BIT]) sp_pa[PA_W-1:SX_BIT] = '1;
         else               sp_pa[VA_W-1:SX_BIT] = '0;
      end
   end else begin : g_nosx
      assign sp_pa = req_va & PA_MASK;
   end

   logic [MODE_W-1:0] eff_mode;
   dxl_mode_sel #(.MODE_W(MODE_W)) u_mode (
      .pc_low (req_pc_low),
      .use_alt(req_alt),
      .cur    (cur_mode),
      .alt    (alt_mode),
      .eff    (eff_mode)
   );

   dxl_fault_e      perm_fault;
   logic [FL_W-1:0] perm_flags;
   dxl_perm #(.NMODE(NMODE), .MODE_W(MODE_W)) u_perm (
      .is_wr(req_write),
      .mode (eff_mode),
      .rd_en(lk_rd_en),
      .wr_en(lk_wr_en),
      .fo_rd(lk_fault_rd),
      .fo_wr(lk_fault_wr),
      .fault(perm_fault),
      .flags(perm_flags)
   );

   logic [VA_W-1:0] raw_pa;
   dxl_fault_e      post_fault;
   logic            post_unc;
   logic [PA_W-1:0] post_pa;
   dxl_pa_post #(.CHK_W(VA_W), .PA_W(PA_W)) u_post (
      .raw  (raw_pa),
      .fault(post_fault),
      .unc  (post_unc),
      .pa   (post_pa)
   );

   dxl_fault_e      nx_fault;
   logic [FL_W-1:0] nx_flags;
   logic [PA_W-1:0] nx_pa;
   logic            nx_unc;
   logic            use_post;

   always_comb begin
      nx_fault = DXL_OK;
      nx_flags = '0;
      raw_pa   = '0;
      use_post = 1'b0;
      if (misaligned) begin
         nx_fault        = DXL_ALIGN;
         nx_flags[FL_WR] = req_write;
      end else if (req_phys) begin
         raw_pa   = req_va;
         use_post = 1'b1;
      end else if (!va_ok) begin
         nx_fault           = DXL_BADVA;
         nx_flags[FL_WR]    = req_write;
         nx_flags[FL_BADVA] = 1'b1;
         nx_flags[FL_ACV]   = 1'b1;
      end else if (is_sp) begin
         if (cur_mode != MODE_KERNEL) begin
            nx_fault         = DXL_SPAGE;
            nx_flags[FL_WR]  = req_write;
            nx_flags[FL_ACV] = 1'b1;
         end else begin
            raw_pa   = sp_pa;
            use_post = 1'b1;
         end
      end else if (!lk_hit) begin
         nx_fault          = req_pte ? DXL_MISS_PTE : DXL_MISS;
         nx_flags[FL_WR]   = req_write;
         nx_flags[FL_MISS] = 1'b1;
      end else if (perm_fault != DXL_OK) begin
         nx_fault = perm_fault;
         nx_flags = perm_flags;
      end else begin
         raw_pa   = VA_W'({lk_ppn, req_va[PAGE_SHIFT-1:0]});
         use_post = 1'b1;
      end
      nx_pa  = '0;
      nx_unc = 1'b0;
      if (use_post) begin
         nx_fault = post_fault;
         nx_pa    = post_pa;
         nx_unc   = post_unc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_pa      <= '0;
         rsp_uncache <= 1'b0;
         rsp_fault   <= '0;
         rsp_flags   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_pa      <= nx_pa;
            rsp_uncache <= nx_unc;
            rsp_fault   <= nx_fault;
            rsp_flags   <= nx_flags;
         end
      end
   end

   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_align_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && misaligned) |=> (rsp_fault == DXL_ALIGN));
   p_miss_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault == DXL_MISS || rsp_fault == DXL_MISS_PTE))
         |-> rsp_flags[FL_MISS]);
   p_unc_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_uncache) |-> (rsp_pa[PA_W-1] && rsp_pa[CLR_HI:CLR_LO] == '0));
   p_fault_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != DXL_OK) |-> (rsp_pa == '0 && !rsp_uncache));

endmodule

// File: tb/sim_dxl_check.sv
module sim_dxl_check;

   typedef struct packed {
      logic [63:0] va;
      logic [1:0]  szl;
      logic        wr, phys, pte, pcl, alt;
      logic [1:0]  cur, altm;
      logic        sp, hit;
      logic [30:0] ppn;
      logic [3:0]  rde, wre;
      logic        fr, fw;
      logic [3:0]  ef;
      logic [5:0]  efl;
      logic        eunc;
      logic [43:0] epa;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      // R8 plain hit load
      '{64'h12345678, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'hABC, 4'hF,4'hF, 1'b0,1'b0, 4'd0, 6'h00, 1'b0, 44'h1579678, 8'd8},
      // R3 misaligned store
      '{64'h12345679, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'hABC, 4'hF,4'hF, 1'b0,1'b0, 4'd1, 6'h01, 1'b0, 44'h0, 8'd3},
      // R3 misaligned beats bypass
      '{64'h6, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 4'd1, 6'h00, 1'b0, 44'h0, 8'd3},
      // R4 bypass ignores miss and permission
      '{64'h12_3456_7000, 2'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 4'd0, 6'h00, 1'b0, 44'h012_3456_7000, 8'd4},
      // R4 bypass out of range
      '{64'h0001_0000_0000_0000, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h0, 4'hF,4'hF, 1'b0,1'b0, 4'd8, 6'h00, 1'b0, 44'h0, 8'd4},
      // R5 bad va store
      '{64'h0000_8000_0000_0000, 2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h0, 4'hF,4'hF, 1'b0,1'b0, 4'd2, 6'h07, 1'b0, 44'h0, 8'd5},
      // R6 superpage bit40 set, lands uncached
      '{64'hFFFF_FD00_0000_1230, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 4'd0, 6'h00, 1'b1, 44'h800_0000_1230, 8'd6},
      // R6 superpage bit40 clear
      '{64'hFFFF_FC12_3456_7000, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 4'd0, 6'h00, 1'b0, 44'h012_3456_7000, 8'd6},
      // R6 superpage from user mode store
      '{64'hFFFF_FC12_3456_7000, 2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b1,1'b1, 31'h0, 4'hF,4'hF, 1'b0,1'b0, 4'd3, 6'h05, 1'b0, 44'h0, 8'd6},
      // R7 window disabled, goes to lookup and misses
      '{64'hFFFF_FC12_3456_7000, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'hF,4'hF, 1'b0,1'b0, 4'd4, 6'h08, 1'b0, 44'h0, 8'd7},
      // R7 page table fetch miss, store
      '{64'h4000, 2'd0, 1'b1,1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'hF,4'hF, 1'b0,1'b0, 4'd5, 6'h09, 1'b0, 44'h0, 8'd7},
      // R10 store denied in user, fault-on-write also set
      '{64'h4000, 2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0,1'b1, 31'h1, 4'hF,4'h7, 1'b0,1'b1, 4'd6, 6'h25, 1'b0, 44'h0, 8'd10},
      // R11 store allowed, fault-on-write
      '{64'h4000, 2'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0,1'b1, 31'h1, 4'hF,4'hF, 1'b0,1'b1, 4'd7, 6'h21, 1'b0, 44'h0, 8'd11},
      // R10 load denied in supervisor, fault-on-read also set
      '{64'h4000, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b0,1'b1, 31'h1, 4'hB,4'hF, 1'b1,1'b0, 4'd6, 6'h14, 1'b0, 44'h0, 8'd10},
      // R11 load allowed, fault-on-read
      '{64'h4000, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b0,1'b1, 31'h1, 4'hF,4'hF, 1'b1,1'b0, 4'd7, 6'h10, 1'b0, 44'h0, 8'd11},
      // R9 pc low bit forces kernel
      '{64'h2010, 2'd0, 1'b0,1'b0,1'b0,1'b1,1'b0, 2'd3,2'd0, 1'b0,1'b1, 31'h1, 4'h1,4'h0, 1'b0,1'b0, 4'd0, 6'h00, 1'b0, 44'h2010, 8'd9},
      // R9 pc low bit with alternate mode
      '{64'h2010, 2'd0, 1'b0,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd2, 1'b0,1'b1, 31'h1, 4'h1,4'h0, 1'b0,1'b0, 4'd6, 6'h04, 1'b0, 44'h0, 8'd9},
      // R9 alternate flag ignored without pc low bit
      '{64'h2010, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'd1,2'd0, 1'b0,1'b1, 31'h1, 4'h1,4'h0, 1'b0,1'b0, 4'd6, 6'h04, 1'b0, 44'h0, 8'd9},
      // R12 register space
      '{64'h40, 2'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h5000_0000, 4'hF,4'hF, 1'b0,1'b0, 4'd9, 6'h00, 1'b0, 44'h0, 8'd12},
      // R12 uncached hit
      '{64'h8, 2'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1, 31'h7FFF_FFFF, 4'hF,4'hF, 1'b0,1'b0, 4'd0, 6'h00, 1'b1, 44'h807_FFFF_E008, 8'd12},
      // R12 uncached bypass
      '{64'hFFF_0000_0000, 2'd0, 1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0, 31'h0, 4'h0,4'h0, 1'b0,1'b0, 4'd0, 6'h00, 1'b1, 44'h807_0000_0000, 8'd12}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_va = '0;
   logic [1:0]  req_size_log2 = '0;
   logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0;
   logic        req_pte = 1'b0, req_pc_low = 1'b0;
   logic [1:0]  cur_mode = '0, alt_mode = '0;
   logic        spage_en = 1'b0;
   logic [34:0] lk_vpn;
   logic        lk_hit = 1'b0;
   logic [30:0] lk_ppn = '0;
   logic [3:0]  lk_rd_en = '0, lk_wr_en = '0;
   logic        lk_fault_rd = 1'b0, lk_fault_wr = 1'b0;
   logic        rsp_valid;
   logic [43:0] rsp_pa;
   logic        rsp_uncache;
   logic [3:0]  rsp_fault;
   logic [5:0]  rsp_flags;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   dxl_check u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_size_log2(req_size_log2), .req_write(req_write), .req_phys(req_phys),
      .req_alt(req_alt), .req_pte(req_pte), .req_pc_low(req_pc_low),
      .cur_mode(cur_mode), .alt_mode(alt_mode), .spage_en(spage_en),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
      .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache),
      .rsp_fault(rsp_fault), .rsp_flags(rsp_flags)
   );

   task automatic check(input int rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(1, "rsp_valid", 64'(rsp_valid), 64'd0);
      check(1, "rsp_fault", 64'(rsp_fault), 64'd0);
      check(1, "rsp_flags", 64'(rsp_flags), 64'd0);
      check(1, "rsp_pa",    64'(rsp_pa),    64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 nothing requested yet
      check(2, "idle rsp_valid", 64'(rsp_valid), 64'd0);

      for (int i = 0; i < NV; i++) begin
         req_valid     = 1'b1;
         req_va        = VEC[i].va;
         req_size_log2 = VEC[i].szl;
         req_write     = VEC[i].wr;
         req_phys      = VEC[i].phys;
         req_pte       = VEC[i].pte;
         req_pc_low    = VEC[i].pcl;
         req_alt       = VEC[i].alt;
         cur_mode      = VEC[i].cur;
         alt_mode      = VEC[i].altm;
         spage_en      = VEC[i].sp;
         lk_hit        = VEC[i].hit;
         lk_ppn        = VEC[i].ppn;
         lk_rd_en      = VEC[i].rde;
         lk_wr_en      = VEC[i].wre;
         lk_fault_rd   = VEC[i].fr;
         lk_fault_wr   = VEC[i].fw;
         @(negedge clk);
         check(2, "rsp_valid", 64'(rsp_valid), 64'd1);
         check(int'(VEC[i].rq), "rsp_fault",   64'(rsp_fault),   64'(VEC[i].ef));
         check(int'(VEC[i].rq), "rsp_flags",   64'(rsp_flags),   64'(VEC[i].efl));
         check(int'(VEC[i].rq), "rsp_uncache", 64'(rsp_uncache), 64'(VEC[i].eunc));
         check(int'(VEC[i].rq), "rsp_pa",      64'(rsp_pa),      64'(VEC[i].epa));
      end

      // R2 valid drops one cycle after the request does
      req_valid = 1'b0;
      @(negedge clk);
      check(2, "rsp_valid after idle", 64'(rsp_valid), 64'd0);

      // R13 no fault code on a clean superpage hit in kernel through pc low bit
      req_valid = 1'b1; req_va = 64'hFFFF_FC00_0000_0100; req_size_log2 = 2'd0;
      req_write = 1'b0; req_phys = 1'b0; req_pc_low = 1'b1; req_alt = 1'b0;
      cur_mode = 2'd0; spage_en = 1'b1;
      @(negedge clk);
      check(13, "fault none", 64'(rsp_fault), 64'd0);
      check(6, "superpage pa", 64'(rsp_pa), 64'h0100);
      req_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule